// File: doc/BRIEF.md
# Direct-Mapped Four-Word-Line Cache

This block is a direct-mapped cache placed between a processor's word request port and a slower memory port. The processor raises a request with an address and, for stores, a data word, then holds the request unchanged until the cache answers with a one-cycle acknowledge. The cache has 4096 lines. Each line keeps a valid flag, a 16-bit tag and a block of four 32-bit words. A load that finds its line returns one word, chosen by the word-select bits of the address, two clock edges after the request is accepted. The processor is not stalled on such a hit.

A load that misses raises the stall output. The cache then reads the whole four-word block from memory, lowest word first. Each word is written into the line as it arrives. The tag and the valid flag are written together with the last word. The cache then repeats the lookup, which now hits, and answers the processor. Stores are written through to memory every time. On a store hit the cached word is also updated. A store miss leaves the cache untouched, so no line is allocated on a write.

Top module: `dm_line_cache`

## Requirements
- R1: Address bits [31:16] form the tag, bits [15:4] form the line index and bits [3:2] select the word within the line. Bits [1:0] have no effect on a lookup: an address that differs from a cached one only in bits [1:0] hits and returns the same word.
- R2: Reset clears every valid flag, so the first load to any address after reset misses.
- R3: A lookup hits only if the indexed line is valid and its stored tag equals the address tag. A load to the same index with a different tag misses and replaces the line.
- R4: A load hit raises cpu_ack on the second rising edge after the request is first seen. cpu_rdata then holds the selected word, cpu_stall stays low and no memory request is issued.
- R5: A load miss raises cpu_stall and issues exactly four memory reads, each with mem_we low. Their addresses share the block's bits [31:4] and have bits [3:2] equal to 0, 1, 2 and 3 in that order, with bits [1:0] zero. After the reads, cpu_ack returns the word held in memory.
- R6: Once a refill completes, loads to every word of that block hit until the line is replaced.
- R7: A store hit issues exactly one memory write with mem_we high, carrying the request's address and data. A later load of that word hits and returns the stored data.
- R8: A store miss issues exactly one memory write and allocates no line, so a later load of that address misses and fetches the stored data from memory.
- R9: cpu_ack is a single-cycle pulse. After reset, cpu_ack, cpu_stall and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while cpu_ack is high |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_stall | output | 1 | High while a miss refill or a memory write is in progress |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle memory completion pulse |

## Verification
Two operations share a clock edge in this design. The edge that takes the last refill word writes that word into the line and also installs the tag and the valid flag. A store hit updates the cached word on the same edge that launches its write to memory. The bench provokes the first case with load misses. It judges it by loading the other words of the block right after the refill and checking that they hit, with no memory reads and with the correct data. It provokes the second case with a store to a freshly filled line. It judges it by a following load that must hit and return the new word, and by the memory write log.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_REPLAY,
    ST_WMEM
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int INDEX_W = 12,
  parameter int TAG_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  input  logic               inst_en,
  input  logic [INDEX_W-1:0] inst_idx,
  input  logic [TAG_W-1:0]   inst_tag
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  // valid flags live in flops so reset can clear them all at once
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= valid_q[rd_idx];
      if (inst_en) valid_q[inst_idx] <= 1'b1;
    end
  end

  // tag array: plain synchronous RAM, read-before-write
  always_ff @(posedge clk) begin
    if (inst_en) tag_mem[inst_idx] <= inst_tag;
    rd_tag <= tag_mem[rd_idx];
  end

  // R6: an installed line reads back valid when its index is looked up next
  p_install_visible_r6: assert property (@(posedge clk) disable iff (rst)
    (inst_en && inst_idx == rd_idx) ##1 (inst_idx == $past(inst_idx) && $stable(rd_idx))
      |=> rd_valid);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int INDEX_W = 12,
  parameter int WORD_W  = 32,
  parameter int WPL     = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [INDEX_W-1:0]      rd_idx,
  output logic [WORD_W*WPL-1:0]   rd_line,
  input  logic [WPL-1:0]          wr_en,
  input  logic [INDEX_W-1:0]      wr_idx,
  input  logic [WORD_W-1:0]       wr_word
);
  localparam int LINES = 1 << INDEX_W;

  // one RAM bank per word lane, each with its own write enable
  for (genvar g = 0; g < WPL; g++) begin : g_bank
    logic [WORD_W-1:0] bank [LINES];
    always_ff @(posedge clk) begin
      if (wr_en[g]) bank[wr_idx] <= wr_word;
      rd_line[g*WORD_W +: WORD_W] <= bank[rd_idx];
    end
  end

  // R7 / R5: at most one word lane is written on any edge
  p_one_lane_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int INDEX_W = 12,
  parameter int WOFF_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [WORD_W-1:0]          cpu_wdata,
  output logic [WORD_W-1:0]          cpu_rdata,
  output logic                       cpu_ack,
  output logic                       cpu_stall,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [WORD_W-1:0]          mem_wdata,
  input  logic [WORD_W-1:0]          mem_rdata,
  input  logic                       mem_ack,
  input  logic                       rd_valid,
  input  logic [ADDR_W-INDEX_W-WOFF_W-$clog2(WORD_W/8)-1:0] rd_tag,
  input  logic [WORD_W*(1<<WOFF_W)-1:0] rd_line,
  output logic [(1<<WOFF_W)-1:0]     data_we,
  output logic [INDEX_W-1:0]         line_idx,
  output logic [WORD_W-1:0]          data_word,
  output logic                       inst_en,
  output logic [ADDR_W-INDEX_W-WOFF_W-$clog2(WORD_W/8)-1:0] inst_tag
);
  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int TAG_W  = ADDR_W - INDEX_W - WOFF_W - BOFF_W;
  localparam int WPL    = 1 << WOFF_W;
  localparam int IDX_LO = BOFF_W + WOFF_W;
  localparam int TAG_LO = IDX_LO + INDEX_W;

  dmc_state_e        state;
  logic [WOFF_W-1:0] fill_cnt;
  logic [TAG_W-1:0]  req_tag;
  logic [WOFF_W-1:0] req_off;
  logic              hit;
  logic              fill_last;
  logic [WORD_W-1:0] sel_word;

  assign req_tag   = cpu_addr[ADDR_W-1:TAG_LO];
  assign req_off   = cpu_addr[IDX_LO-1:BOFF_W];
  assign line_idx  = cpu_addr[TAG_LO-1:IDX_LO];
  assign hit       = rd_valid && (rd_tag == req_tag);
  assign fill_last = (fill_cnt == WOFF_W'(WPL - 1));
  assign sel_word  = rd_line[req_off*WORD_W +: WORD_W];

  // cache-side writes: refill words and store-hit updates
  always_comb begin
    data_we   = '0;
    data_word = cpu_wdata;
    inst_en   = 1'b0;
    inst_tag  = req_tag;
    if (state == ST_FILL) begin
      data_word = mem_rdata;
      if (mem_ack) begin
        data_we[fill_cnt] = 1'b1;
        inst_en           = fill_last;
      end
    end else if (state == ST_LOOK && cpu_we && hit) begin
      data_we[req_off] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      fill_cnt  <= '0;
      cpu_rdata <= '0;
      cpu_ack   <= 1'b0;
      cpu_stall <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      cpu_ack <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cpu_req) state <= ST_LOOK;
        end
        ST_LOOK: begin
          if (cpu_we) begin
            cpu_stall <= 1'b1;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cpu_addr;
            mem_wdata <= cpu_wdata;
            state     <= ST_WMEM;
          end else if (hit) begin
            cpu_rdata <= sel_word;
            cpu_ack   <= 1'b1;
            cpu_stall <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            cpu_stall <= 1'b1;
            mem_req   <= 1'b1;
            mem_we    <= 1'b0;
            fill_cnt  <= '0;
            mem_addr  <= {cpu_addr[ADDR_W-1:IDX_LO], {WOFF_W{1'b0}}, {BOFF_W{1'b0}}};
            state     <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            fill_cnt <= fill_cnt + 1'b1;
            mem_addr <= {cpu_addr[ADDR_W-1:IDX_LO], WOFF_W'(fill_cnt + 1'b1),
                         {BOFF_W{1'b0}}};
            if (fill_last) begin
              mem_req <= 1'b0;
              state   <= ST_REPLAY;
            end
          end
        end
        ST_REPLAY: begin
          // arrays are re-read on this edge with the freshly installed line
          state <= ST_LOOK;
        end
        ST_WMEM: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            cpu_ack   <= 1'b1;
            cpu_stall <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);

  // R5: a refill always begins with word 0 of the block
  p_fill_first_word_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && !mem_we) |-> (mem_addr[IDX_LO-1:BOFF_W] == '0));

  // R4: a load hit starts no memory traffic
  p_hit_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK && !cpu_we && hit) |=> (!mem_req && cpu_ack));

  // R9: the processor is never acknowledged while memory is still busy
  p_no_ack_with_mem_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ack);
endmodule

// File: rtl/dm_line_cache.sv
module dm_line_cache #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int INDEX_W = 12,
  parameter int WOFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ack,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int TAG_W  = ADDR_W - INDEX_W - WOFF_W - BOFF_W;
  localparam int WPL    = 1 << WOFF_W;
  localparam int LINE_W = WORD_W * WPL;

  logic               rd_valid;
  logic [TAG_W-1:0]   rd_tag;
  logic [LINE_W-1:0]  rd_line;
  logic [WPL-1:0]     data_we;
  logic [INDEX_W-1:0] line_idx;
  logic [WORD_W-1:0]  data_word;
  logic               inst_en;
  logic [TAG_W-1:0]   inst_tag;

  dmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (line_idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .inst_en  (inst_en),
    .inst_idx (line_idx),
    .inst_tag (inst_tag)
  );

  dmc_data_store #(.INDEX_W(INDEX_W), .WORD_W(WORD_W), .WPL(WPL)) u_data (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (line_idx),
    .rd_line (rd_line),
    .wr_en   (data_we),
    .wr_idx  (line_idx),
    .wr_word (data_word)
  );

  dmc_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .INDEX_W(INDEX_W), .WOFF_W(WOFF_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_ack   (cpu_ack),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_line   (rd_line),
    .data_we   (data_we),
    .line_idx  (line_idx),
    .data_word (data_word),
    .inst_en   (inst_en),
    .inst_tag  (inst_tag)
  );
endmodule

// File: tb/dm_line_cache_bench.sv
module dm_line_cache_bench;
  localparam int LAT  = 3;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ack;
  logic        cpu_stall;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dm_line_cache u_dm_line_cache (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // ---------------- behavioural memory, fixed latency ----------------
  logic [31:0] wr_map [logic [31:0]];
  logic [31:0] rd_log [4];
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [31:0] last_wr_addr = '0;
  logic [31:0] last_wr_data = '0;
  logic        m_busy = 1'b0;
  logic        m_we = 1'b0;
  logic [31:0] m_addr = '0;
  logic [31:0] m_data = '0;
  int          m_cnt = 0;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    logic [31:0] k;
    k = {a[31:2], 2'b00};
    if (wr_map.exists(k)) return wr_map[k];
    return k ^ 32'h5A3C_96E1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy    <= 1'b0;
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (m_busy) begin
        if (m_cnt == 0) begin
          mem_ack <= 1'b1;
          m_busy  <= 1'b0;
          if (m_we) wr_map[{m_addr[31:2], 2'b00}] = m_data;
          else mem_rdata <= mem_val(m_addr);
        end else begin
          m_cnt <= m_cnt - 1;
        end
      end else if (mem_req && !mem_ack) begin
        m_busy <= 1'b1;
        m_we   <= mem_we;
        m_addr <= mem_addr;
        m_data <= mem_wdata;
        m_cnt  <= LAT - 1;
        if (mem_we) begin
          wr_cnt       <= wr_cnt + 1;
          last_wr_addr <= mem_addr;
          last_wr_data <= mem_wdata;
        end else begin
          rd_log[rd_cnt % 4] <= mem_addr;
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  // ---------------- check helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_access(input logic we, input logic [31:0] a, input logic [31:0] d,
                           output logic [31:0] rd, output int cyc, output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0; stalls = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cpu_stall) stalls++;
    end while (!cpu_ack && cyc < 500);
    rd = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  // columns: store flag, address, store data, expected miss
  localparam logic [65:0] VEC [NVEC] = '{
    {1'b0, 32'h0001_0040, 32'h0000_0000, 1'b1},
    {1'b0, 32'h0001_0044, 32'h0000_0000, 1'b0},
    {1'b0, 32'h0001_004C, 32'h0000_0000, 1'b0},
    {1'b1, 32'h0001_0048, 32'hDEAD_BEEF, 1'b0},
    {1'b0, 32'h0001_0048, 32'h0000_0000, 1'b0},
    {1'b0, 32'h0001_0043, 32'h0000_0000, 1'b0},
    {1'b0, 32'h0002_0040, 32'h0000_0000, 1'b1},
    {1'b0, 32'h0001_0044, 32'h0000_0000, 1'b1},
    {1'b1, 32'h0003_0100, 32'h1234_5678, 1'b0},
    {1'b0, 32'h0003_0100, 32'h0000_0000, 1'b1},
    {1'b0, 32'h0003_010C, 32'h0000_0000, 1'b0},
    {1'b0, 32'hFFFF_FFFC, 32'h0000_0000, 1'b1},
    {1'b0, 32'hFFFF_FFF0, 32'h0000_0000, 1'b0},
    {1'b0, 32'h0001_1040, 32'h0000_0000, 1'b1}
  };
  string vtag [NVEC] = '{"R2", "R6", "R6", "R7", "R7", "R1", "R3",
                         "R3", "R8", "R8", "R6", "R5", "R4", "R1"};

  initial begin
    logic [31:0] rd;
    int cyc, stalls, rc0, wc0;

    repeat (3) @(negedge clk);
    // R9: idle outputs after reset
    check(!cpu_ack && !cpu_stall && !mem_req, "R9 reset outputs",
          {29'd0, cpu_ack, cpu_stall, mem_req}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic        v_we;
      logic [31:0] v_addr, v_data;
      logic        v_miss;
      {v_we, v_addr, v_data, v_miss} = VEC[i];
      rc0 = rd_cnt; wc0 = wr_cnt;
      do_access(v_we, v_addr, v_data, rd, cyc, stalls);
      if (v_we) begin
        check(wr_cnt - wc0 == 1, {vtag[i], " one memory write"}, wr_cnt - wc0, 1);
        check(last_wr_addr == v_addr && last_wr_data == v_data,
              {vtag[i], " write-through data"}, last_wr_data, v_data);
        check(rd_cnt == rc0, {vtag[i], " store makes no reads"}, rd_cnt - rc0, 0);
      end else begin
        check(rd == mem_val(v_addr), {vtag[i], " load data"}, rd, mem_val(v_addr));
        if (v_miss) begin
          check(rd_cnt - rc0 == 4, {vtag[i], " R5 refill read count"}, rd_cnt - rc0, 4);
          for (int w = 0; w < 4; w++)
            check(rd_log[(rc0 + w) % 4] == {v_addr[31:4], 2'(w), 2'b00},
                  {vtag[i], " R5 refill order"}, rd_log[(rc0 + w) % 4],
                  {v_addr[31:4], 2'(w), 2'b00});
          check(stalls > 0, {vtag[i], " R5 stall on miss"}, stalls, 1);
        end else begin
          check(rd_cnt == rc0, {vtag[i], " R4 hit makes no reads"}, rd_cnt - rc0, 0);
          check(cyc == 2, {vtag[i], " R4 hit latency"}, cyc, 2);
          check(stalls == 0, {vtag[i], " R4 no stall on hit"}, stalls, 0);
        end
      end
    end

    // R9: acknowledge lasts one cycle
    do_access(1'b0, 32'h0001_0040, 32'h0, rd, cyc, stalls);
    @(negedge clk);
    check(!cpu_ack, "R9 ack single pulse", cpu_ack, 0);

    // R2: reset in mid-run invalidates the previously filled line
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rc0 = rd_cnt;
    do_access(1'b0, 32'h0001_0040, 32'h0, rd, cyc, stalls);
    check(rd_cnt - rc0 == 4, "R2 miss after reset", rd_cnt - rc0, 4);
    check(rd == mem_val(32'h0001_0040), "R2 data after reset", rd, mem_val(32'h0001_0040));

    // R7: store hit right after a refill, then load back the neighbour words
    wc0 = wr_cnt; rc0 = rd_cnt;
    do_access(1'b1, 32'h0001_004C, 32'hA5A5_0F0F, rd, cyc, stalls);
    do_access(1'b0, 32'h0001_004C, 32'h0, rd, cyc, stalls);
    check(rd == 32'hA5A5_0F0F, "R7 store hit visible", rd, 32'hA5A5_0F0F);
    check(rd_cnt == rc0 && wr_cnt - wc0 == 1, "R7 store hit traffic", rd_cnt - rc0, 0);
    do_access(1'b0, 32'h0001_0048, 32'h0, rd, cyc, stalls);
    check(rd == mem_val(32'h0001_0048) && cyc == 2, "R6 neighbour hit", rd,
          mem_val(32'h0001_0048));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000 && !done) begin
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end
endmodule